// File: doc/BRIEF.md
# Two-Level Cached Register File

This block presents a large architectural register space to a pipeline while keeping only a small working set in a heavily ported first-level store. Six read ports and three write ports name architectural registers directly. A fully associative tag lookup finds which first-level entry holds each named register. Registers that are not resident live in a larger second-level store, which has one read port and one write port.

When any enabled port names a register that is not resident, the block raises `stall` in the same cycle. The pipeline must hold the whole request steady while `stall` is high. During the stall the block does three things for one missing port at a time:
- It picks a victim entry with a round-robin pointer. The pointer skips every entry the current request uses.
- If the victim is dirty, it copies the victim out to the second level.
- It brings in the requested register.

A read miss waits one cycle for the second level's registered read. A write miss only claims an entry, because the write replaces the whole value. Once every port hits, `stall` drops. Read data is valid in that cycle, and the writes take effect at the closing clock edge.

Top module: `regcache_top`

## Requirements
- R1: After reset, with no port enabled, `stall` is low. Every register reads as zero the first time it is accessed.
- R2: When every enabled port hits, `stall` stays low. All six read ports return their registers' current values in that same cycle.
- R3: A read of a non-resident register holds `stall` high for exactly 2 cycles: one to issue the second-level read and one to install the returned value. The value appears on the port in the cycle `stall` falls.
- R4: A write to a non-resident register holds `stall` high for exactly 1 cycle, whether or not a dirty victim has to be copied out. The entry is claimed without fetching the old value.
- R5: Writes take effect only at the clock edge that ends a cycle with `stall` low. A read port naming a register that a write port targets in the same request returns the old value, both during the stall and in the release cycle.
- R6: When several write ports target the same register in one cycle, the highest-numbered port's data is stored.
- R7: Misses in one request are handled one after another, read ports 0..5 before write ports 0..2. `stall` lasts the sum of the individual miss costs: 2 per read miss and 1 per write miss.
- R8: A register pushed out of the first level keeps its last written value. Reading it later returns that value.
- R9: The victim is never an entry that an enabled port of the current request uses. A request that touches nine distinct registers therefore returns and stores correct values even when the first level is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | NRD | Read port enables |
| rd_addr | input | NRD*AW | Architectural register number per read port (port p at bits p*AW) |
| rd_data | output | NRD*DW | Read data per read port (port p at bits p*DW), valid while `stall` is low |
| wr_en | input | NWR | Write port enables |
| wr_addr | input | NWR*AW | Architectural register number per write port |
| wr_data | input | NWR*DW | Write data per write port |
| stall | output | 1 | High while a miss is being handled; the request must be held |

## Verification
The risky overlap is a pending write commit meeting another port's miss in the same request. The bench sends one request in which write port 0 updates a resident register that read port 0 also reads, while read port 1 misses. In every stalled cycle and in the release cycle, read port 0 must still show the old value. Only a later request may see the new value. The bench also fills the first level past capacity, so dirty spills and fills use the second level's two ports in the same cycle. Every pushed-out register must then read back with its last written value.

// File: rtl/regcache_pkg.sv
package regcache_pkg;

  typedef enum logic [0:0] {
    RC_LOOKUP = 1'b0,
    RC_FILL   = 1'b1
  } rc_state_e;

endpackage

// File: rtl/regcache_l1.sv
module regcache_l1 #(
  parameter int DEPTH = 32,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NRD   = 6,
  parameter int NWR   = 3,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0]           rd_en,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0]           rd_hit,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  input  logic [NWR-1:0]           wr_en,
  input  logic [NWR-1:0][AW-1:0]   wr_addr,
  input  logic [NWR-1:0][DW-1:0]   wr_data,
  output logic [NWR-1:0]           wr_hit,
  input  logic                     commit,
  output logic [DEPTH-1:0]         busy,
  input  logic                     ins_en,
  input  logic [IW-1:0]            ins_idx,
  input  logic [AW-1:0]            ins_tag,
  input  logic [DW-1:0]            ins_data,
  input  logic                     ins_dirty,
  input  logic [IW-1:0]            vic_idx,
  output logic                     vic_valid,
  output logic                     vic_dirty,
  output logic [AW-1:0]            vic_tag,
  output logic [DW-1:0]            vic_data
);

  logic [DEPTH-1:0]         valid_all;
  logic [DEPTH-1:0]         dirty_all;
  logic [DEPTH-1:0][AW-1:0] tag_all;
  logic [DEPTH-1:0][DW-1:0] data_all;
  logic [NRD-1:0][DEPTH-1:0] rmatch;
  logic [NWR-1:0][DEPTH-1:0] wmatch;

  for (genvar p = 0; p < NRD; p++) begin : g_rtag
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign rmatch[p][e] = valid_all[e] && (tag_all[e] == rd_addr[p]);
    end
    assign rd_hit[p] = |rmatch[p];

    assert_single_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rmatch[p]) <= 1);
  end

  for (genvar w = 0; w < NWR; w++) begin : g_wtag
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign wmatch[w][e] = valid_all[e] && (tag_all[e] == wr_addr[w]);
    end
    assign wr_hit[w] = |wmatch[w];

    assert_commit_resident_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && wr_en[w]) |-> wr_hit[w]);
  end

  always_comb begin
    busy = '0;
    for (int p = 0; p < NRD; p++) if (rd_en[p]) busy = busy | rmatch[p];
    for (int w = 0; w < NWR; w++) if (wr_en[w]) busy = busy | wmatch[w];
  end

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rd_data[p] = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (rmatch[p][e]) rd_data[p] = rd_data[p] | data_all[e];
      end
    end
  end

  assign vic_valid = valid_all[vic_idx];
  assign vic_dirty = dirty_all[vic_idx];
  assign vic_tag   = tag_all[vic_idx];
  assign vic_data  = data_all[vic_idx];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic          v_q, v_d, d_q, d_d, ld;
    logic [AW-1:0] t_q, t_d;
    logic [DW-1:0] x_q, x_d;

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      t_d = t_q;
      x_d = x_q;
      ld  = 1'b0;
      if (ins_en && (ins_idx == IW'(e))) begin
        v_d = 1'b1;
        d_d = ins_dirty;
        t_d = ins_tag;
        x_d = ins_data;
        ld  = 1'b1;
      end
      for (int w = 0; w < NWR; w++) begin
        if (commit && wr_en[w] && wmatch[w][e]) begin
          x_d = wr_data[w];
          d_d = 1'b1;
          ld  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        t_q <= t_d;
        x_q <= x_d;
      end
    end

    assign valid_all[e] = v_q;
    assign dirty_all[e] = d_q;
    assign tag_all[e]   = t_q;
    assign data_all[e]  = x_q;
  end

endmodule

// File: rtl/regcache_victim.sv
module regcache_victim #(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] busy,
  input  logic             advance,
  output logic [IW-1:0]    victim
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] cand;
  logic          found;

  always_comb begin
    victim = ptr_q;
    found  = 1'b0;
    cand   = ptr_q;
    for (int i = 0; i < DEPTH; i++) begin
      cand = ptr_q + IW'(i);
      if (!found && !busy[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = victim + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assert_victim_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !busy[victim]);

endmodule

// File: rtl/regcache_l2.sv
module regcache_l2 #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] init_q, init_d;
  logic [DW-1:0]    rd_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    init_d = init_q;
    if (wr_en) init_d[wr_addr] = 1'b1;
    rd_d = init_q[rd_addr] ? mem[rd_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      rd_data <= '0;
    end else begin
      init_q <= init_d;
      if (rd_en) rd_data <= rd_d;
    end
  end

  assert_no_rw_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rd_addr != wr_addr));

endmodule

// File: rtl/regcache_ctrl.sv
module regcache_ctrl
  import regcache_pkg::*;
#(
  parameter int NRD = 6,
  parameter int NWR = 3,
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int IW  = 5,
  localparam int NP = NRD + NWR,
  localparam int PW = $clog2(NP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0]         rd_en,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  input  logic [NRD-1:0]         rd_hit,
  input  logic [NWR-1:0]         wr_en,
  input  logic [NWR-1:0][AW-1:0] wr_addr,
  input  logic [NWR-1:0]         wr_hit,
  input  logic [IW-1:0]          victim,
  input  logic                   vic_valid,
  input  logic                   vic_dirty,
  input  logic [DW-1:0]          l2_rd_data,
  output logic                   stall,
  output logic                   commit,
  output logic                   advance,
  output logic                   ins_en,
  output logic [IW-1:0]          ins_idx,
  output logic [AW-1:0]          ins_tag,
  output logic [DW-1:0]          ins_data,
  output logic                   ins_dirty,
  output logic                   l2_rd_en,
  output logic [AW-1:0]          l2_rd_addr,
  output logic                   l2_wr_en
);

  rc_state_e             state_q, state_d;
  logic [IW-1:0]         fill_idx_q;
  logic [AW-1:0]         fill_tag_q;
  logic                  fill_ld;
  logic [NP-1:0]         miss;
  logic [NP-1:0][AW-1:0] port_addr;
  logic [PW-1:0]         sel;

  assign miss      = {wr_en & ~wr_hit, rd_en & ~rd_hit};
  assign port_addr = {wr_addr, rd_addr};
  assign commit    = (state_q == RC_LOOKUP) && !(|miss);
  assign stall     = !commit;

  always_comb begin
    sel = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (miss[i]) sel = PW'(i);
    end
  end

  always_comb begin
    state_d    = state_q;
    fill_ld    = 1'b0;
    advance    = 1'b0;
    ins_en     = 1'b0;
    ins_idx    = victim;
    ins_tag    = port_addr[sel];
    ins_data   = '0;
    ins_dirty  = 1'b1;
    l2_rd_en   = 1'b0;
    l2_rd_addr = port_addr[sel];
    l2_wr_en   = 1'b0;
    case (state_q)
      RC_LOOKUP: begin
        if (|miss) begin
          advance  = 1'b1;
          l2_wr_en = vic_valid && vic_dirty;
          if (sel < PW'(NRD)) begin
            l2_rd_en = 1'b1;
            fill_ld  = 1'b1;
            state_d  = RC_FILL;
          end else begin
            ins_en = 1'b1;
          end
        end
      end
      RC_FILL: begin
        ins_en    = 1'b1;
        ins_idx   = fill_idx_q;
        ins_tag   = fill_tag_q;
        ins_data  = l2_rd_data;
        ins_dirty = 1'b0;
        state_d   = RC_LOOKUP;
      end
      default: state_d = RC_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RC_LOOKUP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (fill_ld) begin
      fill_idx_q <= victim;
      fill_tag_q <= port_addr[sel];
    end
  end

endmodule

// File: rtl/regcache_top.sv
module regcache_top #(
  parameter int L1_DEPTH = 32,
  parameter int L2_DEPTH = 256,
  parameter int DW       = 32,
  parameter int NRD      = 6,
  parameter int NWR      = 3,
  localparam int AW      = $clog2(L2_DEPTH),
  localparam int IW      = $clog2(L1_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRD-1:0]    rd_en,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*DW-1:0] wr_data,
  output logic              stall
);

  logic [NRD-1:0][AW-1:0] ra;
  logic [NRD-1:0][DW-1:0] rd;
  logic [NWR-1:0][AW-1:0] wa;
  logic [NWR-1:0][DW-1:0] wd;
  logic [NRD-1:0]         rd_hit;
  logic [NWR-1:0]         wr_hit;
  logic [L1_DEPTH-1:0]    busy;
  logic                   commit, advance;
  logic                   ins_en, ins_dirty;
  logic [IW-1:0]          ins_idx, victim;
  logic [AW-1:0]          ins_tag, vic_tag, l2_rd_addr;
  logic [DW-1:0]          ins_data, vic_data, l2_rd_data;
  logic                   vic_valid, vic_dirty;
  logic                   l2_rd_en, l2_wr_en;

  assign ra      = rd_addr;
  assign wa      = wr_addr;
  assign wd      = wr_data;
  assign rd_data = rd;

  regcache_l1 #(.DEPTH(L1_DEPTH), .AW(AW), .DW(DW), .NRD(NRD), .NWR(NWR)) u_l1 (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(ra), .rd_hit(rd_hit), .rd_data(rd),
    .wr_en(wr_en), .wr_addr(wa), .wr_data(wd), .wr_hit(wr_hit),
    .commit(commit), .busy(busy),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_tag(ins_tag),
    .ins_data(ins_data), .ins_dirty(ins_dirty),
    .vic_idx(victim), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_tag(vic_tag), .vic_data(vic_data)
  );

  regcache_victim #(.DEPTH(L1_DEPTH)) u_victim (
    .clk(clk), .rst_n(rst_n), .busy(busy), .advance(advance), .victim(victim)
  );

  regcache_l2 #(.DEPTH(L2_DEPTH), .DW(DW)) u_l2 (
    .clk(clk), .rst_n(rst_n),
    .rd_en(l2_rd_en), .rd_addr(l2_rd_addr), .rd_data(l2_rd_data),
    .wr_en(l2_wr_en), .wr_addr(vic_tag), .wr_data(vic_data)
  );

  regcache_ctrl #(.NRD(NRD), .NWR(NWR), .AW(AW), .DW(DW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(ra), .rd_hit(rd_hit),
    .wr_en(wr_en), .wr_addr(wa), .wr_hit(wr_hit),
    .victim(victim), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .l2_rd_data(l2_rd_data),
    .stall(stall), .commit(commit), .advance(advance),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_tag(ins_tag),
    .ins_data(ins_data), .ins_dirty(ins_dirty),
    .l2_rd_en(l2_rd_en), .l2_rd_addr(l2_rd_addr), .l2_wr_en(l2_wr_en)
  );

endmodule

// File: tb/regcache_top_tb.sv
`timescale 1ns/1ps
module regcache_top_tb;

  localparam int NRD = 6;
  localparam int NWR = 3;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic              clk;
  logic              rst_n;
  logic [NRD-1:0]    rd_en;
  logic [NRD*AW-1:0] rd_addr;
  logic [NRD*DW-1:0] rd_data;
  logic [NWR-1:0]    wr_en;
  logic [NWR*AW-1:0] wr_addr;
  logic [NWR*DW-1:0] wr_data;
  logic              stall;

  int n_chk;
  int n_fail;
  logic [DW-1:0] model [256];

  regcache_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stall(stall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] port_rd(input int p);
    return rd_data[p*DW +: DW];
  endfunction

  task automatic clear_req();
    rd_en = '0; rd_addr = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_rd(input int p, input int a);
    rd_en[p] = 1'b1;
    rd_addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic set_wr(input int w, input int a, input logic [DW-1:0] d);
    wr_en[w] = 1'b1;
    wr_addr[w*AW +: AW] = AW'(a);
    wr_data[w*DW +: DW] = d;
  endtask

  // Inputs are set just after a falling edge; runs the request to completion.
  task automatic run_req(input int exp_stall, input string req);
    int n;
    #2;
    n = 0;
    while (stall && n < 60) begin
      @(negedge clk); #2;
      n++;
    end
    if (exp_stall >= 0) chk(n == exp_stall, req, n, exp_stall);
    for (int p = 0; p < NRD; p++) begin
      if (rd_en[p]) begin
        logic [DW-1:0] e;
        e = model[rd_addr[p*AW +: AW]];
        chk(port_rd(p) == e, req, port_rd(p), e);
      end
    end
    for (int w = 0; w < NWR; w++) begin
      if (wr_en[w]) model[wr_addr[w*AW +: AW]] = wr_data[w*DW +: DW];
    end
    @(negedge clk);
    clear_req();
  endtask

  task automatic t_reset();
    #2;
    chk(stall == 1'b0, "R1 idle stall", stall, 0);
    @(negedge clk);
    set_rd(0, 5);
    run_req(2, "R1 zero fill");
  endtask

  task automatic t_write_miss();
    set_wr(0, 10, 32'hA0A0_0010);
    run_req(1, "R4 write miss");
    set_rd(0, 10);
    run_req(0, "R4 read after write");
  endtask

  task automatic t_six_reads();
    set_wr(0, 20, 32'h2000_0020); set_wr(1, 21, 32'h2100_0021); set_wr(2, 22, 32'h2200_0022);
    run_req(3, "R7 three write misses");
    set_wr(0, 23, 32'h2300_0023); set_wr(1, 24, 32'h2400_0024); set_wr(2, 25, 32'h2500_0025);
    run_req(3, "R7 three write misses b");
    for (int p = 0; p < NRD; p++) set_rd(p, 20 + p);
    run_req(0, "R2 six read hits");
  endtask

  task automatic t_read_miss();
    set_rd(3, 100);
    run_req(2, "R3 read miss");
  endtask

  task automatic t_same_cycle();
    int n;
    set_rd(0, 10); set_rd(1, 101); set_wr(0, 10, 32'hB0B0_0010);
    #2;
    chk(stall == 1'b1, "R5 stall raised", stall, 1);
    n = 0;
    while (stall && n < 60) begin
      chk(port_rd(0) == model[10], "R5 no commit under stall", port_rd(0), model[10]);
      @(negedge clk); #2;
      n++;
    end
    chk(n == 2, "R5 stall length", n, 2);
    chk(port_rd(0) == model[10], "R5 old value at release", port_rd(0), model[10]);
    chk(port_rd(1) == model[101], "R5 missing port data", port_rd(1), model[101]);
    model[10] = 32'hB0B0_0010;
    @(negedge clk);
    clear_req();
    set_rd(0, 10);
    run_req(0, "R5 new value visible");
  endtask

  task automatic t_dup_write();
    set_wr(0, 30, 32'h1111_1111); set_wr(1, 30, 32'h2222_2222); set_wr(2, 30, 32'h3333_3333);
    run_req(1, "R6 duplicate write");
    set_rd(2, 30);
    run_req(0, "R6 highest port wins");
    chk(model[30] == 32'h3333_3333, "R6 model", model[30], 32'h3333_3333);
  endtask

  task automatic t_multi_miss();
    set_rd(0, 150); set_rd(1, 151); set_rd(2, 152); set_wr(0, 153, 32'h1530_0153);
    run_req(7, "R7 mixed misses");
    set_rd(0, 153);
    run_req(0, "R7 write landed");
  endtask

  task automatic t_evict();
    for (int r = 200; r < 240; r++) begin
      set_wr(r % NWR, r, 32'hC000_0000 + DW'(r * 7));
      run_req(1, "R4 write miss with spill");
    end
    for (int r = 200; r < 240; r++) begin
      set_rd(r % NRD, r);
      run_req(-1, "R8 evicted value");
    end
    set_rd(0, 10); set_rd(1, 20); set_rd(2, 25);
    run_req(-1, "R8 older values");
  endtask

  task automatic t_full_request();
    for (int p = 0; p < NRD; p++) set_rd(p, 200 + p * 3);
    set_wr(0, 241, 32'hD000_0241); set_wr(1, 242, 32'hD000_0242); set_wr(2, 243, 32'hD000_0243);
    run_req(-1, "R9 nine distinct registers");
    set_rd(0, 241); set_rd(1, 242); set_rd(2, 243);
    run_req(0, "R9 writes resident");
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    clear_req();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_miss();
    t_six_reads();
    t_read_miss();
    t_same_cycle();
    t_dup_write();
    t_multi_miss();
    t_evict();
    t_full_request();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule